// File: doc/BRIEF.md
# Four-Floor Elevator Direction Controller

This block steers a single elevator car across four floors. It latches hall calls (an up call at each of the three lower floors and a down call at each of the three upper floors) and car calls (one destination button per floor), and keeps them pending until the car serves them. A direction state machine holds the car's position and travel direction. It stops the car at a floor only when that floor has something to serve, and it reverses only when nothing remains ahead.

A stop is handed to a separate door sequencer. The sequencer opens the door, spends three cycles taking destination presses, closes the door, and then returns a one-cycle done pulse. Only after that pulse may the car move again. Movement is paced by an external step strobe: the car advances by at most one floor per strobe. The outputs are a one-hot floor code for a position display, a direction flag, and a one-hot per-floor door indicator.

Top module: `elev_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no requests, the floor code is 0001, the direction flag is 1 (up) and all door indicators are 0.
- R2: While any pending request lies on a floor beyond the car in its travel direction, the direction flag does not change, and the car does not stop at a floor that has only a hall call for the other direction.
- R3: The floor code is one-hot: bit 0 for floor 1, bit 1 for floor 2, bit 2 for floor 3, bit 3 for floor 4.
- R4: With no request pending, the car stays parked: the floor code and the direction flag hold and no door opens.
- R5: At floor 1, a pending up call there opens the door at floor 1. Otherwise, if a request lies above, the next step strobe moves the car to floor 2 with the direction flag at 1.
- R6: A stop lasts five cycles: four with the door open (open, then three accepting cycles) and one with it closed. The car does not change floor from the start of the stop until the cycle after the closed cycle.
- R7: At most one door indicator is 1 at any time, and only the one for the floor the car is at.
- R8: When no request lies ahead but one lies behind, the direction flag reverses and the car returns to serve it.
- R9: The floor changes only in the cycle after a step strobe (`move_tick` = 1) and only to an adjacent floor.
- R10: Serving a floor clears its car call and its hall call for the travel direction. The hall call for the opposite direction is kept, unless the car turns round at that floor.
- R11: A call for the floor whose door is open, pressed while it is open, is discarded.
- R12: Hall inputs are packed: `hall_up[i]` is the up call at floor i+1 and `hall_dn[i]` is the down call at floor i+2. A one-cycle pulse on any request input is latched until it is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| move_tick | input | 1 | Step strobe: allows one floor of travel |
| hall_up | input | 3 | Up hall calls, floors 1 to 3 |
| hall_dn | input | 3 | Down hall calls, floors 2 to 4 |
| car_call | input | 4 | Destination buttons, floors 1 to 4 |
| floor_oh | output | 4 | One-hot current floor |
| dir_up | output | 1 | Travel direction, 1 = up |
| door_open | output | 4 | One-hot open-door indicator per floor |

## Verification
The embedded assertions check on every cycle that the floor and door codes are well formed and agree with each other. They also check that the car only steps to an adjacent floor after a strobe and never moves during a stop, that the door sequencer walks its states in order, that the direction holds while work lies ahead, and that a parked car with nothing pending stays put. The bench's scenarios cover what needs a history of calls: passing an opposite-direction hall call on the way up, turning round at the top, keeping an opposite call that was not yet served, discarding presses made while the door is open, and waiting for the strobe. A behavioural reference model compared on every clock covers the cycle timing of all of these.

// File: rtl/elev_pkg.sv
package elev_pkg;
  typedef enum logic [1:0] {
    M_PARK,
    M_RUN,
    M_DOOR
  } mstate_e;

  typedef enum logic [2:0] {
    D_IDLE,
    D_OPEN,
    D_ACC1,
    D_ACC2,
    D_ACC3,
    D_CLOSE
  } dstate_e;
endpackage

// File: rtl/elev_req.sv
module elev_req #(
  parameter int N_FLOORS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_FLOORS-2:0] hall_up_i,
  input  logic [N_FLOORS-2:0] hall_dn_i,
  input  logic [N_FLOORS-1:0] car_i,
  input  logic [N_FLOORS-1:0] clr_car_i,
  input  logic [N_FLOORS-1:0] clr_up_i,
  input  logic [N_FLOORS-1:0] clr_dn_i,
  output logic [N_FLOORS-1:0] car_q_o,
  output logic [N_FLOORS-1:0] up_q_o,
  output logic [N_FLOORS-1:0] dn_q_o
);
  logic [N_FLOORS-1:0] up_in, dn_in;
  logic [N_FLOORS-1:0] car_d, up_d, dn_d;
  logic [N_FLOORS-1:0] car_q, up_q, dn_q;

  // top floor has no up call, bottom floor no down call
  assign up_in = {1'b0, hall_up_i};
  assign dn_in = {hall_dn_i, 1'b0};

  // a clear wins over a new press at the same floor
  always_comb begin
    car_d = (car_q | car_i) & ~clr_car_i;
    up_d  = (up_q  | up_in) & ~clr_up_i;
    dn_d  = (dn_q  | dn_in) & ~clr_dn_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q <= '0;
      up_q  <= '0;
      dn_q  <= '0;
    end else begin
      car_q <= car_d;
      up_q  <= up_d;
      dn_q  <= dn_d;
    end
  end

  assign car_q_o = car_q;
  assign up_q_o  = up_q;
  assign dn_q_o  = dn_q;

  AST_NO_UP_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    !up_q[N_FLOORS-1] && !dn_q[0]) else $error("edge hall call latched"); // R12
endmodule

// File: rtl/elev_door.sv
module elev_door
  import elev_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic open_o,
  output logic done_o,
  output logic busy_o
);
  dstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      D_IDLE:  if (start_i) state_d = D_OPEN;
      D_OPEN:  state_d = D_ACC1;
      D_ACC1:  state_d = D_ACC2;
      D_ACC2:  state_d = D_ACC3;
      D_ACC3:  state_d = D_CLOSE;
      D_CLOSE: state_d = D_IDLE;
      default: state_d = D_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= D_IDLE;
    else        state_q <= state_d;
  end

  assign open_o = (state_q == D_OPEN) || (state_q == D_ACC1) ||
                  (state_q == D_ACC2) || (state_q == D_ACC3);
  assign done_o = (state_q == D_CLOSE);
  assign busy_o = (state_q != D_IDLE);

  AST_SEQ_OPEN:  assert property (@(posedge clk) disable iff (!rst_n)
    state_q == D_OPEN |=> state_q == D_ACC1) else $error("seq"); // R6
  AST_SEQ_ACC:   assert property (@(posedge clk) disable iff (!rst_n)
    state_q == D_ACC3 |=> state_q == D_CLOSE) else $error("seq"); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done pulse"); // R6
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> state_q == D_IDLE) else $error("start while busy"); // R6
endmodule

// File: rtl/elev_master.sv
module elev_master
  import elev_pkg::*;
#(
  parameter int N_FLOORS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                move_tick_i,
  input  logic [N_FLOORS-1:0] car_q_i,
  input  logic [N_FLOORS-1:0] up_q_i,
  input  logic [N_FLOORS-1:0] dn_q_i,
  input  logic                door_open_i,
  input  logic                door_done_i,
  output logic                door_start_o,
  output logic [N_FLOORS-1:0] floor_oh_o,
  output logic                dir_up_o,
  output logic [N_FLOORS-1:0] clr_car_o,
  output logic [N_FLOORS-1:0] clr_up_o,
  output logic [N_FLOORS-1:0] clr_dn_o
);
  localparam int FW = (N_FLOORS > 1) ? $clog2(N_FLOORS) : 1;
  localparam logic [FW-1:0] TOP = FW'(N_FLOORS - 1);

  mstate_e       state_q, state_d;
  logic [FW-1:0] floor_q, floor_d;
  logic          dir_q, dir_d;
  logic          both_q, both_d;

  logic [N_FLOORS-1:0] here, above, below, req_all;
  logic ahead_up, ahead_dn, eff_dir, ahead_eff;
  logic here_car, here_dir_hall, here_any_hall, serve;

  // floor masks relative to the car
  always_comb begin
    for (int i = 0; i < N_FLOORS; i++) begin
      here[i]  = (FW'(i) == floor_q);
      above[i] = (FW'(i) >  floor_q);
      below[i] = (FW'(i) <  floor_q);
    end
  end

  assign req_all  = car_q_i | up_q_i | dn_q_i;
  assign ahead_up = |(req_all & above);
  assign ahead_dn = |(req_all & below);

  // direction choice: keep while work ahead, else turn toward work behind
  always_comb begin
    if (dir_q && ahead_up)        eff_dir = 1'b1;
    else if (!dir_q && ahead_dn)  eff_dir = 1'b0;
    else if (ahead_up)            eff_dir = 1'b1;
    else if (ahead_dn)            eff_dir = 1'b0;
    else                          eff_dir = dir_q;
  end

  assign ahead_eff     = eff_dir ? ahead_up : ahead_dn;
  assign here_car      = |(car_q_i & here);
  assign here_dir_hall = eff_dir ? |(up_q_i & here) : |(dn_q_i & here);
  assign here_any_hall = |((up_q_i | dn_q_i) & here);
  assign serve         = here_car || here_dir_hall || (!ahead_eff && here_any_hall);

  always_comb begin
    state_d      = state_q;
    floor_d      = floor_q;
    dir_d        = dir_q;
    both_d       = both_q;
    door_start_o = 1'b0;
    if (state_q == M_DOOR) begin
      if (door_done_i) state_d = M_RUN;
    end else begin
      dir_d = eff_dir;
      if (serve) begin
        door_start_o = 1'b1;
        both_d       = !ahead_eff;
        state_d      = M_DOOR;
      end else if (ahead_eff) begin
        state_d = M_RUN;
        if (move_tick_i) begin
          if (eff_dir && floor_q != TOP)         floor_d = floor_q + FW'(1);
          else if (!eff_dir && floor_q != '0)    floor_d = floor_q - FW'(1);
        end
      end else begin
        state_d = M_PARK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_PARK;
      floor_q <= '0;
      dir_q   <= 1'b1;
      both_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      floor_q <= floor_d;
      dir_q   <= dir_d;
      both_q  <= both_d;
    end
  end

  // clears apply while the door stands open at this floor
  always_comb begin
    clr_car_o = door_open_i ? here : '0;
    clr_up_o  = (door_open_i && (dir_q || both_q))  ? here : '0;
    clr_dn_o  = (door_open_i && (!dir_q || both_q)) ? here : '0;
  end

  assign floor_oh_o = here;
  assign dir_up_o   = dir_q;

  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(floor_q) |-> $past(move_tick_i)) else $error("move w/o tick"); // R9
  AST_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(floor_q) |-> (floor_q == $past(floor_q) + FW'(1)) ||
                          (floor_q == $past(floor_q) - FW'(1))) else $error("jump"); // R9
  AST_NO_MOVE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == M_DOOR |=> $stable(floor_q)) else $error("moved in stop"); // R6
  AST_KEEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != M_DOOR && dir_q && ahead_up) |=> dir_q) else $error("dir up lost"); // R2
  AST_KEEP_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != M_DOOR && !dir_q && ahead_dn) |=> !dir_q) else $error("dir dn lost"); // R2
  AST_PARK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != M_DOOR && req_all == '0) |=> $stable(floor_q) && $stable(dir_q) && !door_open_i)
    else $error("parked car changed"); // R4
endmodule

// File: rtl/elev_ctrl.sv
module elev_ctrl #(
  parameter int N_FLOORS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                move_tick,
  input  logic [N_FLOORS-2:0] hall_up,
  input  logic [N_FLOORS-2:0] hall_dn,
  input  logic [N_FLOORS-1:0] car_call,
  output logic [N_FLOORS-1:0] floor_oh,
  output logic                dir_up,
  output logic [N_FLOORS-1:0] door_open
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [N_FLOORS-1:0] car_q, up_q, dn_q, clr_car, clr_up, clr_dn, fl_oh;
  logic door_start, door_is_open, door_done, door_busy;

  elev_req #(.N_FLOORS(N_FLOORS)) u_req (
    .clk(clk), .rst_n(rst_int_n),
    .hall_up_i(hall_up), .hall_dn_i(hall_dn), .car_i(car_call),
    .clr_car_i(clr_car), .clr_up_i(clr_up), .clr_dn_i(clr_dn),
    .car_q_o(car_q), .up_q_o(up_q), .dn_q_o(dn_q)
  );

  elev_master #(.N_FLOORS(N_FLOORS)) u_master (
    .clk(clk), .rst_n(rst_int_n), .move_tick_i(move_tick),
    .car_q_i(car_q), .up_q_i(up_q), .dn_q_i(dn_q),
    .door_open_i(door_is_open), .door_done_i(door_done),
    .door_start_o(door_start), .floor_oh_o(fl_oh), .dir_up_o(dir_up),
    .clr_car_o(clr_car), .clr_up_o(clr_up), .clr_dn_o(clr_dn)
  );

  elev_door u_door (
    .clk(clk), .rst_n(rst_int_n), .start_i(door_start),
    .open_o(door_is_open), .done_o(door_done), .busy_o(door_busy)
  );

  assign floor_oh  = fl_oh;
  assign door_open = door_is_open ? fl_oh : '0;

  AST_FLOOR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot(floor_oh)) else $error("floor code"); // R3
  AST_DOOR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(door_open)) else $error("door code"); // R7
  AST_DOOR_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (door_open != '0) |-> (door_open == floor_oh)) else $error("door elsewhere"); // R7
  AST_OPEN_IN_STOP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (door_open != '0) |-> door_busy) else $error("door outside stop"); // R6
endmodule

// File: tb/elev_ctrl_bench.sv
module elev_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic move_tick = 1'b0;
  logic [2:0] hall_up = '0, hall_dn = '0;
  logic [3:0] car_call = '0;
  logic [3:0] floor_oh, door_open;
  logic dir_up;

  always #5 clk = ~clk;

  elev_ctrl u_elev_ctrl (
    .clk(clk), .rst_n(rst_n), .move_tick(move_tick),
    .hall_up(hall_up), .hall_dn(hall_dn), .car_call(car_call),
    .floor_oh(floor_oh), .dir_up(dir_up), .door_open(door_open)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mf;            // floor index 0..3
  bit md;            // direction, 1 = up
  int mm;            // 0 parked, 1 running, 2 stopped
  int mp;            // door phase: 0 idle, 1..4 open, 5 closed
  bit mb;            // clear both hall calls on this stop
  bit pc[4], pu[4], pd[4];
  bit [1:0] msync;

  task automatic model_reset();
    mf = 0; md = 1; mm = 0; mp = 0; mb = 0;
    for (int i = 0; i < 4; i++) begin pc[i] = 0; pu[i] = 0; pd[i] = 0; end
  endtask

  task automatic model_step();
    bit nc[4], nu[4], nd[4];
    bit opn, ahu, ahd, e, ahe, srv, start;
    int nf, nm, np; bit nmd, nmb;
    opn = (mp >= 1 && mp <= 4);
    ahu = 0; ahd = 0;
    for (int i = 0; i < 4; i++) begin
      if (i > mf && (pc[i] || pu[i] || pd[i])) ahu = 1;
      if (i < mf && (pc[i] || pu[i] || pd[i])) ahd = 1;
    end
    nf = mf; nm = mm; nmd = md; nmb = mb; start = 0;
    if (mm == 2) begin
      if (mp == 5) nm = 1;
    end else begin
      if (md && ahu) e = 1; else if (!md && ahd) e = 0;
      else if (ahu) e = 1; else if (ahd) e = 0; else e = md;
      ahe = e ? ahu : ahd;
      srv = pc[mf] || (e ? pu[mf] : pd[mf]) || (!ahe && (pu[mf] || pd[mf]));
      nmd = e;
      if (srv) begin start = 1; nmb = !ahe; nm = 2; end
      else if (ahe) begin
        nm = 1;
        if (move_tick) nf = e ? mf + 1 : mf - 1;
      end else nm = 0;
    end
    if (mp == 0) np = start ? 1 : 0;
    else if (mp == 5) np = 0;
    else np = mp + 1;
    for (int i = 0; i < 4; i++) begin
      nc[i] = pc[i] || car_call[i];
      nu[i] = pu[i] || (i < 3 && hall_up[i]);
      nd[i] = pd[i] || (i > 0 && hall_dn[i-1]);
    end
    if (opn) begin
      nc[mf] = 0;
      if (md || mb)  nu[mf] = 0;
      if (!md || mb) nd[mf] = 0;
    end
    mf = nf; mm = nm; md = nmd; mb = nmb; mp = np;
    for (int i = 0; i < 4; i++) begin pc[i] = nc[i]; pu[i] = nu[i]; pd[i] = nd[i]; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msync = 2'b00;
      model_reset();
    end else begin
      if (!msync[1]) model_reset();
      else model_step();
      msync = {msync[0], 1'b1};
    end
  end

  // compare outputs against the model every cycle, away from the edge
  always @(negedge clk) begin
    if (!finished) begin
      cyc++;
      check(floor_oh == 4'(1 << mf), "R3", "model floor", floor_oh, 1 << mf);
      check(dir_up == md, "R2", "model direction", dir_up, md);
      check(door_open == ((mp >= 1 && mp <= 4) ? 4'(1 << mf) : 4'b0), "R7",
            "model door", door_open, (mp >= 1 && mp <= 4) ? (1 << mf) : 0);
      if (cyc > 20000) begin
        finished = 1;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  // ---------------- directed scenarios ----------------
  task automatic wait_door(output logic [3:0] fl, input int lim);
    fl = 4'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (door_open != 4'b0) begin fl = door_open; break; end
    end
  endtask

  task automatic wait_closed(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (door_open == 4'b0) break;
    end
  endtask

  initial begin
    logic [3:0] fl, f0;
    int cnt;
    repeat (3) @(negedge clk);
    check(floor_oh == 4'b0001 && door_open == 0 && dir_up, "R1", "in reset",
          {door_open, floor_oh}, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(floor_oh == 4'b0001, "R1", "floor after reset", floor_oh, 1);
    check(dir_up == 1'b1 && door_open == 4'b0, "R1", "dir/door after reset",
          {door_open, 3'b0, dir_up}, 1);

    // R4: nothing pending, strobes running
    move_tick = 1'b1;
    repeat (20) @(negedge clk);
    check(floor_oh == 4'b0001 && door_open == 0 && dir_up, "R4", "parked idle",
          floor_oh, 1);
    move_tick = 1'b0;

    // R5/R12: up call at floor 1 (hall_up[0]) opens door at floor 1
    hall_up[0] = 1'b1; @(negedge clk); hall_up[0] = 1'b0;
    @(negedge clk);
    check(door_open == 4'b0001, "R5", "door at floor 1", door_open, 1);
    cnt = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (door_open != 0) cnt++;
    end
    check(cnt == 4, "R6", "door open cycles", cnt, 4);
    check(floor_oh == 4'b0001, "R10", "served call not repeated", floor_oh, 1);

    // R5/R2/R8: car call floor 4 plus down call at floor 2 (hall_dn[0])
    move_tick = 1'b1;
    car_call[3] = 1'b1; hall_dn[0] = 1'b1; @(negedge clk);
    car_call[3] = 1'b0; hall_dn[0] = 1'b0;
    @(negedge clk);
    check(floor_oh == 4'b0010 && dir_up, "R5", "first step up", {3'b0, dir_up, floor_oh}, 8'h12);
    wait_door(fl, 50);
    check(fl == 4'b1000, "R2", "passes opposite call, stops at 4", fl, 8);
    check(dir_up == 1'b0, "R8", "reversed at top", dir_up, 0);
    wait_closed(10);
    wait_door(fl, 50);
    check(fl == 4'b0010, "R8", "returns to floor 2", fl, 2);
    wait_closed(10);
    repeat (30) @(negedge clk);
    check(floor_oh == 4'b0010 && door_open == 0, "R4", "parked at 2", floor_oh, 2);
    check(door_open == 4'b0, "R10", "no reopen after serve", door_open, 0);

    // R9: no strobe, no movement; one strobe, one floor
    move_tick = 1'b0;
    car_call[0] = 1'b1; @(negedge clk); car_call[0] = 1'b0;
    repeat (10) @(negedge clk);
    check(floor_oh == 4'b0010, "R9", "held without strobe", floor_oh, 2);
    f0 = floor_oh;
    move_tick = 1'b1; @(negedge clk); move_tick = 1'b0;
    check(floor_oh == 4'b0001 && f0 == 4'b0010, "R9", "single step", floor_oh, 1);
    repeat (3) @(negedge clk);
    check(floor_oh == 4'b0001, "R9", "no second step", floor_oh, 1);

    // R11: press the open floor during the stop
    wait_door(fl, 10);
    check(fl == 4'b0001, "R11", "stop at floor 1", fl, 1);
    car_call[0] = 1'b1; @(negedge clk); car_call[0] = 1'b0;
    wait_closed(10);
    repeat (20) @(negedge clk);
    check(door_open == 4'b0, "R11", "press during open discarded", door_open, 0);

    // R10: up and down calls at floor 2, destination floor 4
    move_tick = 1'b1;
    hall_up[1] = 1'b1; hall_dn[0] = 1'b1; car_call[3] = 1'b1; @(negedge clk);
    hall_up[1] = 1'b0; hall_dn[0] = 1'b0; car_call[3] = 1'b0;
    wait_door(fl, 50);
    check(fl == 4'b0010 && dir_up, "R10", "up call served at 2", fl, 2);
    wait_closed(10);
    wait_door(fl, 50);
    check(fl == 4'b1000, "R2", "continues to 4", fl, 8);
    wait_closed(10);
    wait_door(fl, 50);
    check(fl == 4'b0010 && !dir_up, "R10", "down call at 2 kept", fl, 2);
    wait_closed(10);
    move_tick = 1'b0;
    repeat (10) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule